// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory bus of an 8-bit microcontroller core. It turns a core request into one bus cycle: a code fetch, strobed by an active-low program-store strobe, or a data read or data write, strobed by active-low read and write strobes. The low address byte and the data share one bidirectional byte port. An address-latch pulse marks the low address on that port. A second byte port carries the high address.

Every step of the sequencer is one oscillator period, given to the block as a clock enable (`tick`). A code fetch takes three ticks and a data cycle takes six. Requests are taken only on a tick while the sequencer is idle. A data request wins over a fetch offered on the same tick, in the same way a data transfer replaces the code fetches of its machine cycle. When the external-code select is inactive, fetches are served internally: they complete without any bus activity.

The high address byte comes from the program counter for fetches. For data accesses it comes from the data pointer, or from the core's port-2 register when the access is register-indirect. That register is an input to this block and is never written here. A combined active-low read strobe lets one memory device serve both code and data.

Top module: `xbus_seq`

## Requirements
- R1: An external fetch (`eaN`=0) occupies three ticks. Tick 1 has `ale` high. Ticks 2 and 3 have `psenN` low. `busy` is high from the clock after the accepting tick through tick 3. `done` pulses for one clock right after tick 3, and `busy` is low in that clock.
- R2: A data read occupies six ticks. Tick 1 has `ale` high. Tick 2 keeps the address on port 0 with `ale` low. Ticks 3 to 5 have `rdN` low. Tick 6 is a recovery step with all strobes high, and `done` pulses after it.
- R3: A data write has the same six-tick frame, with `wrN` low in ticks 3 to 5. Port 0 drives the write byte with `p0Oe`=1 from tick 2 through tick 6, so the byte is present before `wrN` falls and after it rises.
- R4: In tick 1 of every bus cycle, port 0 drives the low address byte with `p0Oe`=1, and no read or write strobe is active. Port 0 is released (`p0Oe`=0) whenever `psenN` or `rdN` is low.
- R5: During a bus cycle, `p2Out` carries the high address byte. For a fetch this is `pc[15:8]`. For a data access with `useDptr`=1 it is `dptr[15:8]`, and with `useDptr`=0 it is `p2Latch`. With `useDptr`=0 the low byte is `riAddr`.
- R6: A fetch with `eaN`=1 causes no `ale` and no `psenN` activity, leaves `rdData` unchanged, and pulses `done` on the clock after the accepting tick.
- R7: If a data request and a fetch request are both present on the accepting tick, the data access runs and the fetch is dropped. A write request beats a read request. At most one of `psenN`, `rdN` and `wrN` is low at any time.
- R8: `rdCombN` is low exactly when `psenN` or `rdN` is low.
- R9: Requests are sampled only on a clock where `tick`=1 and the sequencer is idle. While `tick`=0, the sequencer's state and all outputs hold.
- R10: Outside a bus cycle, `p2Out` shows `p2Latch` when `eaN`=1. When `eaN`=0, it holds the high address of the last bus cycle, which is 0 after reset.
- R11: `rdData` takes the port 0 input on the tick that ends the last strobe tick of a fetch (tick 3) or of a read (tick 5), while the strobe is still low. `rdData` is 0 after reset and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator-period enable; one sequencer step per tick |
| eaN | input | 1 | Low: fetches go to external code memory |
| fetchReq | input | 1 | Code fetch request |
| dataRdReq | input | 1 | Data read request |
| dataWrReq | input | 1 | Data write request |
| useDptr | input | 1 | Data address from the data pointer (1) or register-indirect (0) |
| pc | input | 16 | Program counter |
| dptr | input | 16 | Data pointer |
| riAddr | input | 8 | Low address for register-indirect transfers |
| p2Latch | input | 8 | Core's port-2 register value |
| wrData | input | 8 | Byte to write |
| p0In | input | 8 | Port 0 input |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Last captured read or fetch byte |
| ale | output | 1 | Address latch pulse |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| rdCombN | output | 1 | Combined read strobe, active low |
| p0Out | output | 8 | Port 0 output value |
| p0Oe | output | 1 | Port 0 output enable |
| p2Out | output | 8 | Port 2 output value |

## Verification
The two functions that can meet on one tick are a code fetch and a data transfer. The bench raises the fetch request and a data read request together on an idle tick, and also a write together with a read. The per-clock reference model expects the data access to run alone. On every clock it checks that the program-store strobe never falls, that `p2Out` carries the data-pointer high byte, and that the byte returned is the one the external memory model serves at the data address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    SRC_PC,
    SRC_DPTR,
    SRC_RI
  } srcT;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;       // latch address and write byte at cycle start
    srcT  src;        // address source for the latch
    logic capture;    // take port 0 input into the read register
    logic driveAddr;  // port 0 carries the low address
    logic driveData;  // port 0 carries the write byte
    logic holdHi;     // port 2 carries the latched high address
  } strobeT;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int FETCH_PH = 3,
  parameter int DATA_PH  = 6
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  logic   eaN,
  input  logic   fetchReq,
  input  logic   dataRdReq,
  input  logic   dataWrReq,
  input  logic   useDptr,
  output logic   ale,
  output logic   psenN,
  output logic   rdN,
  output logic   wrN,
  output logic   busy,
  output logic   done,
  output strobeT strb
);
  localparam int PH_W = $clog2(DATA_PH);
  localparam logic [PH_W-1:0] FETCH_LAST = PH_W'(FETCH_PH - 1);
  localparam logic [PH_W-1:0] DATA_LAST  = PH_W'(DATA_PH - 1);
  localparam logic [PH_W-1:0] STRB_FIRST = PH_W'(2);
  localparam logic [PH_W-1:0] STRB_LAST  = PH_W'(DATA_PH - 2);
  localparam logic [PH_W-1:0] ADDR_HOLD  = PH_W'(1);

  typedef enum logic [1:0] {K_IDLE, K_FETCH, K_READ, K_WRITE} kindT;

  kindT            kind;
  logic [PH_W-1:0] phase;
  logic idleTick, dataAny, startWr, startRd, startFetch, intFetch;
  logic lastPh, inStrobe;

  always_comb begin
    idleTick   = tick && (kind == K_IDLE);
    dataAny    = dataRdReq || dataWrReq;
    startWr    = idleTick && dataWrReq;
    startRd    = idleTick && !dataWrReq && dataRdReq;
    startFetch = idleTick && !dataAny && fetchReq && !eaN;
    intFetch   = idleTick && !dataAny && fetchReq && eaN;
    lastPh     = (kind == K_FETCH) ? (phase == FETCH_LAST) : (phase == DATA_LAST);
    inStrobe   = (phase >= STRB_FIRST) && (phase <= STRB_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind  <= K_IDLE;
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (startWr) begin
        kind  <= K_WRITE;
        phase <= '0;
      end else if (startRd) begin
        kind  <= K_READ;
        phase <= '0;
      end else if (startFetch) begin
        kind  <= K_FETCH;
        phase <= '0;
      end else if (intFetch) begin
        done <= 1'b1;
      end else if (tick && kind != K_IDLE) begin
        if (lastPh) begin
          kind  <= K_IDLE;
          phase <= '0;
          done  <= 1'b1;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

  always_comb begin
    busy  = (kind != K_IDLE);
    ale   = busy && (phase == '0);
    psenN = !((kind == K_FETCH) && (phase != '0));
    rdN   = !((kind == K_READ) && inStrobe);
    wrN   = !((kind == K_WRITE) && inStrobe);

    strb.load      = startWr || startRd || startFetch;
    strb.src       = startFetch ? SRC_PC : (useDptr ? SRC_DPTR : SRC_RI);
    strb.capture   = tick && (((kind == K_FETCH) && (phase == FETCH_LAST)) ||
                              ((kind == K_READ) && (phase == STRB_LAST)));
    strb.driveAddr = busy && ((phase == '0) || ((kind == K_READ) && (phase == ADDR_HOLD)));
    strb.driveData = (kind == K_WRITE) && (phase != '0);
    strb.holdHi    = busy || !eaN;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!psenN, !rdN, !wrN}) <= 1); // R7
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (psenN && rdN && wrN)); // R4
  AST_INT_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    intFetch |=> (done && !busy && psenN && !ale)); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> ($stable(phase) && $stable(kind))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R1

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] riAddr,
  input  logic [DATA_W-1:0] p2Latch,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] p0In,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Oe,
  output logic [DATA_W-1:0] p2Out
);
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [DATA_W-1:0] wrReg, rdReg;

  always_comb begin
    unique case (strb.src)
      SRC_PC:   addrNext = pc;
      SRC_DPTR: addrNext = dptr;
      default:  addrNext = {p2Latch, riAddr};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
    end else begin
      if (strb.load) begin
        addrReg <= addrNext;
        wrReg   <= wrData;
      end
      if (strb.capture) rdReg <= p0In;
    end
  end

  always_comb begin
    rdData = rdReg;
    p0Oe   = strb.driveAddr || strb.driveData;
    p0Out  = strb.driveData ? wrReg :
             (strb.driveAddr ? addrReg[DATA_W-1:0] : '0);
    p2Out  = strb.holdHi ? addrReg[ADDR_W-1:DATA_W] : p2Latch;
  end

  AST_RELEASE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !p0Oe); // R11

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int FETCH_PH = 3,
  parameter  int DATA_PH  = 6,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              eaN,
  input  logic              fetchReq,
  input  logic              dataRdReq,
  input  logic              dataWrReq,
  input  logic              useDptr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] riAddr,
  input  logic [DATA_W-1:0] p2Latch,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] p0In,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              rdCombN,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Oe,
  output logic [DATA_W-1:0] p2Out
);
  strobeT strb;

  xbus_ctrl #(.FETCH_PH(FETCH_PH), .DATA_PH(DATA_PH)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .eaN(eaN),
    .fetchReq(fetchReq), .dataRdReq(dataRdReq), .dataWrReq(dataWrReq),
    .useDptr(useDptr), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .busy(busy), .done(done), .strb(strb)
  );

  xbus_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pc(pc), .dptr(dptr),
    .riAddr(riAddr), .p2Latch(p2Latch), .wrData(wrData), .p0In(p0In),
    .rdData(rdData), .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out)
  );

  // one device for code and data: low when either read strobe is low
  assign rdCombN = psenN & rdN;

  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> (p0Oe && $past(p0Oe))); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> p0Oe); // R3

endmodule

// File: tb/test_xbus_seq.sv
`timescale 1ns/1ps
module test_xbus_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick, eaN, fetchReq, dataRdReq, dataWrReq, useDptr;
  logic [15:0] pc, dptr;
  logic [7:0] riAddr, p2Latch, wrData, p0In;
  logic busy, done, ale, psenN, rdN, wrN, rdCombN, p0Oe;
  logic [7:0] rdData, p0Out, p2Out;

  always #5 clk = ~clk;

  xbus_seq i_xbus_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .eaN(eaN), .fetchReq(fetchReq),
    .dataRdReq(dataRdReq), .dataWrReq(dataWrReq), .useDptr(useDptr),
    .pc(pc), .dptr(dptr), .riAddr(riAddr), .p2Latch(p2Latch),
    .wrData(wrData), .p0In(p0In), .busy(busy), .done(done),
    .rdData(rdData), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .rdCombN(rdCombN), .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tickRate = 1;
  int tickCnt = 0;
  bit started = 0;

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // tick generator
  assign tick = (tickCnt == 0);
  always @(posedge clk) tickCnt <= (tickCnt + 1 >= tickRate) ? 0 : tickCnt + 1;

  // external memory: address latch while ale high, byte = lo ^ A5 ^ hi
  logic [7:0] extLo = 8'h00, extHi = 8'h00, wrSeenD = 8'h00;
  logic [15:0] wrSeenA = 16'h0;
  always @(posedge clk) if (ale === 1'b1) begin extLo <= p0Out; extHi <= p2Out; end
  assign p0In = (psenN === 1'b0 || rdN === 1'b0) ? (extLo ^ 8'hA5 ^ extHi) : 8'hFF;
  always @(posedge clk) if (rstN && wrN === 1'b0) begin
    wrSeenD <= p0Out; wrSeenA <= {extHi, extLo};
  end

  // behavioural reference model: kind 0 idle, 1 fetch, 2 read, 3 write
  int mKind = 0, mPh = 0;
  logic [15:0] mAddr = 16'h0;
  logic [7:0] mWr = 8'h0, mRd = 8'h0;
  bit mDone = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mKind <= 0; mPh <= 0; mAddr <= 0; mWr <= 0; mRd <= 0; mDone <= 0;
    end else begin
      mDone <= 0;
      if (tick) begin
        if (mKind == 0) begin
          if (dataWrReq || dataRdReq) begin
            mKind <= dataWrReq ? 3 : 2; mPh <= 0; mWr <= wrData;
            mAddr <= useDptr ? dptr : {p2Latch, riAddr};
          end else if (fetchReq && !eaN) begin
            mKind <= 1; mPh <= 0; mAddr <= pc;
          end else if (fetchReq) mDone <= 1;
        end else begin
          if ((mKind == 1 && mPh == 2) || (mKind == 2 && mPh == 4)) mRd <= p0In;
          if (mPh == ((mKind == 1) ? 2 : 5)) begin
            mKind <= 0; mPh <= 0; mDone <= 1;
          end else mPh <= mPh + 1;
        end
      end
    end
  end

  // per-clock comparison, away from the edges
  always @(negedge clk) begin
    #2;
    if (rstN && started) begin
      bit eOe;
      eOe = (mKind != 0) && (mPh == 0 || mKind == 3 || (mKind == 2 && mPh == 1));
      chk(ale == (mKind != 0 && mPh == 0), "R1 ale", ale, 0);
      chk(psenN == !(mKind == 1 && mPh >= 1), "R1 psenN", psenN, 0);
      chk(rdN == !(mKind == 2 && mPh >= 2 && mPh <= 4), "R2 rdN", rdN, 0);
      chk(wrN == !(mKind == 3 && mPh >= 2 && mPh <= 4), "R3 wrN", wrN, 0);
      chk(rdCombN == (psenN && rdN), "R8 rdCombN", rdCombN, 0);
      chk(p0Oe == eOe, "R4 p0Oe", p0Oe, eOe);
      if (eOe)
        chk(p0Out == ((mKind == 3 && mPh > 0) ? mWr : mAddr[7:0]), "R4 p0Out", p0Out,
            (mKind == 3 && mPh > 0) ? mWr : mAddr[7:0]);
      chk(p2Out == ((mKind != 0 || !eaN) ? mAddr[15:8] : p2Latch), "R5 R10 p2Out", p2Out,
          (mKind != 0 || !eaN) ? mAddr[15:8] : p2Latch);
      chk(busy == (mKind != 0), "R9 busy", busy, 0);
      chk(done == mDone, "R1 done", done, mDone);
      chk(rdData == mRd, "R11 rdData", rdData, mRd);
    end
  end

  task automatic access(bit f, bit r, bit w, bit sel);
    @(negedge clk);
    while (!(tick && mKind == 0)) @(negedge clk);
    fetchReq = f; dataRdReq = r; dataWrReq = w; useDptr = sel;
    @(posedge clk); #1;
    fetchReq = 0; dataRdReq = 0; dataWrReq = 0;
    while (!mDone) @(negedge clk);
    #2;
  endtask

  initial begin
    eaN = 0; fetchReq = 0; dataRdReq = 0; dataWrReq = 0; useDptr = 0;
    pc = 16'h1234; dptr = 16'hBEEF; riAddr = 8'h3C; p2Latch = 8'h77; wrData = 8'h5E;
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 0 && done == 0 && ale == 0, "R1 reset idle", {busy, done, ale}, 0);
    chk(psenN && rdN && wrN && rdCombN && !p0Oe, "R4 reset strobes", {psenN, rdN, wrN}, 3'b111);
    chk(rdData == 0 && p2Out == 0, "R11 R10 reset values", {rdData, p2Out}, 0);
    rstN = 1; started = 1;

    // R1 R11 external fetches
    pc = 16'h1234; access(1, 0, 0, 0);
    chk(rdData == (8'h34 ^ 8'hA5 ^ 8'h12), "R11 fetch byte", rdData, 8'h34 ^ 8'hA5 ^ 8'h12);
    pc = 16'hF00D; access(1, 0, 0, 0);
    chk(rdData == (8'h0D ^ 8'hA5 ^ 8'hF0), "R1 fetch byte 2", rdData, 8'h0D ^ 8'hA5 ^ 8'hF0);
    // R2 R5 read via data pointer, then register-indirect
    access(0, 1, 0, 1);
    chk(rdData == (8'hEF ^ 8'hA5 ^ 8'hBE), "R2 R5 dptr read", rdData, 8'hEF ^ 8'hA5 ^ 8'hBE);
    access(0, 1, 0, 0);
    chk(rdData == (8'h3C ^ 8'hA5 ^ 8'h77), "R5 ri read", rdData, 8'h3C ^ 8'hA5 ^ 8'h77);
    // R3 write
    dptr = 16'h4321; wrData = 8'hC3; access(0, 0, 1, 1);
    chk(wrSeenD == 8'hC3 && wrSeenA == 16'h4321, "R3 write", {wrSeenD, wrSeenA[7:0]}, {8'hC3, 8'h21});
    // R10 idle port 2 with eaN low holds last high address
    #1; chk(p2Out == 8'h43, "R10 hold hi", p2Out, 8'h43);
    // R6 internal fetch
    eaN = 1; @(negedge clk); #2;
    chk(p2Out == p2Latch, "R10 idle p2Latch", p2Out, p2Latch);
    begin
      logic [7:0] prev;
      prev = rdData;
      access(1, 0, 0, 0);
      chk(done && !busy && rdData == prev, "R6 internal fetch", rdData, prev);
    end
    eaN = 0;
    // R7 simultaneous fetch and read, then write with read
    dptr = 16'hA55A; access(1, 1, 0, 1);
    chk(rdData == (8'h5A ^ 8'hA5 ^ 8'hA5), "R7 data wins", rdData, 8'h5A);
    wrData = 8'h99; access(0, 1, 1, 0);
    chk(wrSeenD == 8'h99 && wrSeenA == {p2Latch, riAddr}, "R7 write wins", wrSeenD, 8'h99);
    // R9 sparse ticks
    tickRate = 3;
    pc = 16'h8001; access(1, 0, 0, 0);
    chk(rdData == (8'h01 ^ 8'hA5 ^ 8'h80), "R9 slow fetch", rdData, 8'h01 ^ 8'hA5 ^ 8'h80);
    dptr = 16'h0102; access(0, 1, 0, 1);
    chk(rdData == (8'h02 ^ 8'hA5 ^ 8'h01), "R9 slow read", rdData, 8'h02 ^ 8'hA5 ^ 8'h01);
    // R9 request on a non-tick clock is ignored
    @(negedge clk);
    while (!(tick == 0 && mKind == 0)) @(negedge clk);
    fetchReq = 1; @(posedge clk); #1; fetchReq = 0;
    repeat (4) @(negedge clk);
    #2; chk(busy == 0, "R9 no tick ignored", busy, 0);
    tickRate = 1;
    access(0, 0, 1, 1);
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule